// File: doc/BRIEF.md
# Processor Status Word Register

This block holds the status and control word of a small processor core. Its low bits are the condition flags: carry, zero, sign, overflow and equal. The ALU result stream updates these flags without any explicit addressing. Conditional branch logic reads them back from the word output. Above the flags sit two control bits: interrupt enable and supervisor mode.

Software has only three direct paths to the flags, and all three act on the carry bit: set it, clear it, or invert it. The control fields change only through privileged operations. One is a full-word write; the other is a mode change that sets the supervisor bit. Both are accepted only while the stored supervisor bit is one. If either is attempted in user mode, the attempt is dropped and a violation pulse is raised for one cycle. The exception machinery uses that pulse.

Every update is registered. The word output changes on the clock edge that follows the request.

Top module: `psw_reg`

## Requirements
- R1: After reset the word reads 0x40. Bit 6 (supervisor) is 1. Bits 0 to 5 and bit 7 are 0. Bit 7 reads 0 at all times.
- R2: When `alu_upd` is 1, the next edge loads bit 0 (carry) from `alu_cy` and bit 3 (overflow) from `alu_ov`. It sets bit 1 (zero) when `alu_res` is all zeros and copies the MSB of `alu_res` into bit 2 (sign).
- R3: An ALU update with `alu_cmp` = 1 loads bit 4 (equal) with 1 if `alu_res` is all zeros (the operands matched) and 0 otherwise. An ALU update with `alu_cmp` = 0 leaves bit 4 unchanged.
- R4: `cy_cmd` controls the carry bit directly: 2'b01 sets bit 0, 2'b10 clears it, 2'b11 inverts its stored value, and 2'b00 does nothing.
- R5: If a carry command and an ALU update arrive in the same cycle, the command decides bit 0. The ALU update still sets bits 1 to 4.
- R6: If there is no ALU update, no carry command and no accepted privileged operation, the word holds its value.
- R7: If supervisor is 1, `word_wr` loads bits 6:0 from `word_data[6:0]`. This write overrides any ALU update or carry command in the same cycle.
- R8: If supervisor is 1, `mode_wr` loads bit 6 from `mode_sup`. It overrides bit 6 of a full-word write in the same cycle.
- R9: If supervisor is 0, `word_wr` and `mode_wr` are ignored. `priv_viol` is 1 in the cycle after the attempt and 0 in the next cycle unless another attempt follows.
- R10: `priv_viol` stays 0 after privileged operations made while supervisor is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alu_upd | input | 1 | ALU result valid; update flags |
| alu_res | input | DATA_W | ALU result |
| alu_cy | input | 1 | Carry out of the ALU |
| alu_ov | input | 1 | Signed overflow out of the ALU |
| alu_cmp | input | 1 | Current ALU operation is a compare |
| cy_cmd | input | 2 | Carry command: 00 none, 01 set, 10 clear, 11 invert |
| word_wr | input | 1 | Privileged full-word write request |
| word_data | input | 8 | Data for the full-word write |
| mode_wr | input | 1 | Privileged mode-change request |
| mode_sup | input | 1 | New supervisor bit value |
| psw | output | 8 | Status word |
| priv_viol | output | 1 | Privilege violation pulse |

## Verification
The bench runs every ALU result value against both compare settings. A zero detector that ignores a bit, or a sign taken from the wrong bit, shows up as a wrong flag. It also crosses all four carry commands with an ALU update and both starting carry values. A design that gives the ALU priority for carry, or inverts the ALU carry instead of the stored carry, fails there. Privileged writes are made in both modes, with and without competing updates in the same cycle. A gate that reads the incoming supervisor bit instead of the stored one, or a violation signal that stays high, is caught by checking the word and the pulse on the cycle after each attempt.

// File: rtl/psw_pkg.sv
package psw_pkg;
   localparam int WORD_W  = 8;
   localparam int B_CARRY = 0;
   localparam int B_ZERO  = 1;
   localparam int B_SIGN  = 2;
   localparam int B_OVF   = 3;
   localparam int B_EQ    = 4;
   localparam int B_IE    = 5;
   localparam int B_SUP   = 6;
   localparam int B_RSVD  = 7;
   localparam logic [WORD_W-1:0] RESET_WORD = 8'h40;

   typedef enum logic [1:0] {
      CY_NONE = 2'b00,
      CY_SET  = 2'b01,
      CY_CLR  = 2'b10,
      CY_INV  = 2'b11
   } cy_op_e;
endpackage

// File: rtl/psw_flag_gen.sv
module psw_flag_gen #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] res,
   input  logic              is_cmp,
   output logic              z_flag,
   output logic              s_flag,
   output logic              eq_hit
);
   if (DATA_W < 1) begin : g_bad_w
      $error("psw_flag_gen: DATA_W must be at least 1");
   end

   assign z_flag = (res == '0);
   assign s_flag = res[DATA_W-1];
   assign eq_hit = is_cmp & z_flag;
endmodule

// File: rtl/psw_carry_ctl.sv
module psw_carry_ctl
   import psw_pkg::*;
#(
   parameter bit CARRY_CMDS = 1'b1
) (
   input  logic   cur_c,
   input  logic   alu_upd,
   input  logic   alu_c,
   input  cy_op_e cmd,
   output logic   nxt_c
);
   logic base_c;
   assign base_c = alu_upd ? alu_c : cur_c;

   if (CARRY_CMDS) begin : g_cmds
      always_comb begin
         unique case (cmd)
            CY_SET:  nxt_c = 1'b1;
            CY_CLR:  nxt_c = 1'b0;
            CY_INV:  nxt_c = ~cur_c;
            default: nxt_c = base_c;
         endcase
      end
   end else begin : g_no_cmds
      assign nxt_c = base_c;
   end
endmodule

// File: rtl/psw_priv_gate.sv
module psw_priv_gate (
   input  logic sup,
   input  logic word_wr,
   input  logic mode_wr,
   output logic word_ok,
   output logic mode_ok,
   output logic viol_d
);
   assign word_ok = word_wr & sup;
   assign mode_ok = mode_wr & sup;
   assign viol_d  = (word_wr | mode_wr) & ~sup;
endmodule

// File: rtl/psw_reg.sv
module psw_reg
   import psw_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter bit CARRY_CMDS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alu_upd,
   input  logic [DATA_W-1:0] alu_res,
   input  logic              alu_cy,
   input  logic              alu_ov,
   input  logic              alu_cmp,
   input  logic [1:0]        cy_cmd,
   input  logic              word_wr,
   input  logic [7:0]        word_data,
   input  logic              mode_wr,
   input  logic              mode_sup,
   output logic [7:0]        psw,
   output logic              priv_viol
);
   localparam int CTRL_HI = B_SUP;

   if (WORD_W != 8) begin : g_bad_word
      $error("psw_reg: status word must be 8 bits");
   end

   logic [WORD_W-1:0] word_q, word_d;
   logic              viol_q;
   logic              z_f, s_f, eq_f, c_nxt;
   logic              word_ok, mode_ok, viol_d;

   psw_flag_gen #(.DATA_W(DATA_W)) u_flags (
      .res    (alu_res),
      .is_cmp (alu_cmp),
      .z_flag (z_f),
      .s_flag (s_f),
      .eq_hit (eq_f)
   );

   psw_carry_ctl #(.CARRY_CMDS(CARRY_CMDS)) u_carry (
      .cur_c   (word_q[B_CARRY]),
      .alu_upd (alu_upd),
      .alu_c   (alu_cy),
      .cmd     (cy_op_e'(cy_cmd)),
      .nxt_c   (c_nxt)
   );

   psw_priv_gate u_gate (
      .sup     (word_q[B_SUP]),
      .word_wr (word_wr),
      .mode_wr (mode_wr),
      .word_ok (word_ok),
      .mode_ok (mode_ok),
      .viol_d  (viol_d)
   );

   always_comb begin
      word_d = word_q;
      if (alu_upd) begin
         word_d[B_ZERO] = z_f;
         word_d[B_SIGN] = s_f;
         word_d[B_OVF]  = alu_ov;
         if (alu_cmp) word_d[B_EQ] = eq_f;
      end
      word_d[B_CARRY] = c_nxt;
      if (word_ok) word_d[CTRL_HI:0] = word_data[CTRL_HI:0];
      if (mode_ok) word_d[B_SUP] = mode_sup;
      word_d[B_RSVD] = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_q <= RESET_WORD;
         viol_q <= 1'b0;
      end else begin
         word_q <= word_d;
         viol_q <= viol_d;
      end
   end

   assign psw       = word_q;
   assign priv_viol = viol_q;

   // R9
   viol_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((word_wr | mode_wr) && !psw[B_SUP]) |=> priv_viol);

   // R9
   user_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((word_wr | mode_wr) && !psw[B_SUP] && !alu_upd && cy_cmd == 2'b00)
      |=> $stable(psw));

   // R10
   sup_no_viol_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (psw[B_SUP] || !(word_wr | mode_wr)) |=> !priv_viol);

   // R6
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!alu_upd && cy_cmd == 2'b00 && !word_wr && !mode_wr) |=> $stable(psw));

   // R5
   carry_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cy_cmd == 2'b01 && !(word_wr && psw[B_SUP])) |=> psw[B_CARRY]);

   // R4
   carry_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cy_cmd == 2'b11 && !(word_wr && psw[B_SUP]))
      |=> psw[B_CARRY] != $past(psw[B_CARRY]));

   // R2
   zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (alu_upd && alu_res == '0 && !(word_wr && psw[B_SUP])) |=> psw[B_ZERO]);

   // R1
   rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !psw[B_RSVD]);
endmodule

// File: tb/tb_psw_reg.sv
`timescale 1ns/1ps
module tb_psw_reg;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       alu_upd, alu_cy, alu_ov, alu_cmp, word_wr, mode_wr, mode_sup;
   logic [7:0] alu_res, word_data;
   logic [1:0] cy_cmd;
   logic [7:0] psw;
   logic       priv_viol;

   int checks = 0;
   int errors = 0;
   logic [7:0] exp_w;

   always #2 clk = ~clk;

   psw_reg #(.DATA_W(8), .CARRY_CMDS(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .alu_upd(alu_upd), .alu_res(alu_res),
      .alu_cy(alu_cy), .alu_ov(alu_ov), .alu_cmp(alu_cmp), .cy_cmd(cy_cmd),
      .word_wr(word_wr), .word_data(word_data), .mode_wr(mode_wr),
      .mode_sup(mode_sup), .psw(psw), .priv_viol(priv_viol)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step(input string req,
                       input logic u, input logic [7:0] r, input logic cy,
                       input logic ov, input logic cmp, input logic [1:0] cmd,
                       input logic ww, input logic [7:0] wd,
                       input logic mw, input logic ms);
      logic [7:0] e;
      logic v;
      @(negedge clk);
      alu_upd = u; alu_res = r; alu_cy = cy; alu_ov = ov; alu_cmp = cmp;
      cy_cmd = cmd; word_wr = ww; word_data = wd; mode_wr = mw; mode_sup = ms;
      e = exp_w;
      v = (ww | mw) & ~exp_w[6];
      if (u) begin
         e[0] = cy; e[1] = (r == 8'h00); e[2] = r[7]; e[3] = ov;
         if (cmp) e[4] = (r == 8'h00);
      end
      case (cmd)
         2'b01: e[0] = 1'b1;
         2'b10: e[0] = 1'b0;
         2'b11: e[0] = ~exp_w[0];
         default: ;
      endcase
      if (ww && exp_w[6]) e[6:0] = wd[6:0];
      if (mw && exp_w[6]) e[6] = ms;
      e[7] = 1'b0;
      exp_w = e;
      @(posedge clk);
      #1;
      check(req, psw, e);
      check(req, {7'd0, priv_viol}, {7'd0, v});
   endtask

   task automatic idle(input string req);
      step(req, 0, 8'h00, 0, 0, 0, 2'b00, 0, 8'h00, 0, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      alu_upd = 0; alu_res = 0; alu_cy = 0; alu_ov = 0; alu_cmp = 0;
      cy_cmd = 0; word_wr = 0; word_data = 0; mode_wr = 0; mode_sup = 0;
      repeat (3) @(posedge clk);
      #1;
      // R1 reset value
      check("R1", psw, 8'h40);
      check("R1", {7'd0, priv_viol}, 8'h00);
      @(negedge clk);
      rst_n = 1'b1;
      exp_w = 8'h40;
      idle("R6");

      // R2/R3: every result value, both compare settings
      for (int i = 0; i < 512; i++) begin
         step((i & 1) ? "R3" : "R2", 1, i[8:1], i[2], i[5], i[0], 2'b00, 0, 8'h00, 0, 0);
      end
      // R3: non-compare leaves equal
      step("R3", 1, 8'h00, 0, 0, 1, 2'b00, 0, 8'h00, 0, 0);
      step("R3", 1, 8'h5a, 0, 0, 0, 2'b00, 0, 8'h00, 0, 0);
      idle("R6");

      // R4/R5: commands x ALU update x ALU carry x starting carry
      for (int c = 0; c < 4; c++) begin
         for (int j = 0; j < 8; j++) begin
            step("R4", 0, 8'h00, 0, 0, 0, j[0] ? 2'b01 : 2'b10, 0, 8'h00, 0, 0);
            step(j[1] ? "R5" : "R4", j[1], 8'h81, j[2], 1, 0, c[1:0], 0, 8'h00, 0, 0);
         end
      end

      // R7: full write in supervisor, overriding ALU and carry command
      step("R7", 1, 8'h00, 1, 1, 1, 2'b01, 1, 8'hea, 0, 0);
      step("R7", 0, 8'h00, 0, 0, 0, 2'b00, 1, 8'h7f, 0, 0);
      // R8: mode change beats full write for supervisor bit
      step("R8", 0, 8'h00, 0, 0, 0, 2'b00, 1, 8'h40, 1, 0);
      // R9: user mode attempts ignored, pulse one cycle
      step("R9", 0, 8'h00, 0, 0, 0, 2'b00, 1, 8'h7f, 0, 0);
      idle("R9");
      step("R9", 0, 8'h00, 0, 0, 0, 2'b00, 0, 8'h00, 1, 1);
      step("R9", 0, 8'h00, 0, 0, 0, 2'b00, 1, 8'hff, 1, 1);
      idle("R9");
      // R9: ALU update still works in user mode alongside a refused write
      step("R9", 1, 8'h80, 1, 0, 0, 2'b11, 1, 8'h7f, 0, 0);
      idle("R6");
      // back to supervisor through reset
      @(negedge clk); rst_n = 1'b0;
      @(posedge clk); #1;
      check("R1", psw, 8'h40);
      @(negedge clk); rst_n = 1'b1;
      exp_w = 8'h40;
      // R10: accepted privileged operations raise no violation
      step("R10", 0, 8'h00, 0, 0, 0, 2'b00, 1, 8'h65, 0, 0);
      step("R10", 0, 8'h00, 0, 0, 0, 2'b00, 0, 8'h00, 1, 1);
      step("R8", 0, 8'h00, 0, 0, 0, 2'b00, 1, 8'h00, 1, 1);
      idle("R6");

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule